// File: doc/BRIEF.md
# ADC Logical-Channel Scheduler

This block sits between a CPU register bus and one analog-to-digital converter. It keeps a set of logical channels (64 by default). Each one carries its own routing field, which names the physical analog input to connect, along with mode bits, status flags and a result register. Several logical channels may name the same physical input. Software can therefore sample one pin many times in a row by setting up consecutive logical channels.

Triggers mark channels as pending. They come from per-channel trigger pulses or from a control-word write. Whenever the converter is idle, the scheduler picks the lowest-numbered pending channel that is eligible. It then issues a one-cycle start pulse with that channel's physical input on the select bus. When the converter reports completion, the result goes into the channel's result word and the channel's done flag is set. A guard bit in each channel stops a channel from being converted again while its last result is still unread. For multiple-conversion channels, the guard also holds the channel back after a group interruption.

The converter side has no back-pressure. The converter asserts `cnv_done_i` for one cycle with `cnv_result_i` valid, and the block always accepts it, because only one conversion is ever outstanding. The bus is word-addressed. Address bit `ADDR_W-1` at 0 selects a channel's control word, and at 1 selects its read-only result word. The low bits give the channel number. Read data appears on `bus_rdata_o` in the cycle after the request. `NUM_CH` must be a power of two.

Top module: `adc_lch_sched`

## Requirements
- R1: After reset, every control word and every result word reads as zero, `cnv_start_o` is low and `cnv_sel_o` is zero.
- R2: Control bits [5:0] hold the physical input number. When a channel is started, `cnv_sel_o` carries exactly that value, and any number of channels may hold the same value.
- R3: Each channel has its own result word. It is written only when that channel's conversion completes, with the value on `cnv_result_i`. A read returns it in the cycle after the request.
- R4: With the guard bit (control bit 6) at 0, a pending channel is converted even while its done flag is set, and its old result is overwritten.
- R5: With the guard bit at 1 and the done flag (control bit 10) at 1, the channel is not started even though it is pending. Reading its result word clears the done flag, and the channel then becomes eligible.
- R6: A channel with the guard bit, the multi-mode bit (bit 7), the group-interrupt enable (bit 8) and the group-interrupted flag (bit 11) all at 1 is not started if a conversion of it has already begun since its group flag was last cleared. Writing a 1 to bit 11 clears the flag and releases it. With the enable at 0, the flag does not block.
- R7: Among the eligible pending channels, the lowest-numbered one is started first. Its pending bit (bit 9) is clear from the cycle in which `cnv_start_o` is high.
- R8: At most one conversion is outstanding. `cnv_start_o` is high for exactly one cycle, and it does not rise again until `cnv_done_i` has been seen.
- R9: `cnv_sel_o` holds steady from the start pulse until the done pulse, even if the channel's control word is rewritten in between.
- R10: If a result is captured for a channel in the same cycle that its result word is read, the done flag ends up set. The read returns the previous result.
- R11: A control write loads bits [8:0]. A 1 in bit 9 sets the pending bit, a 1 in bit 11 clears the group flag, and bit 10 is ignored on write. A pulse on `trig_i[n]` sets channel n's pending bit, and a pulse on `grp_evt_i[n]` sets its group flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_CH | Per-channel trigger pulses |
| grp_evt_i | input | NUM_CH | Per-channel group-interruption events |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | ADDR_W | Word address: top bit selects result word, low bits channel |
| bus_wdata_i | input | 12 | Write data |
| bus_rdata_o | output | 12 | Read data, valid the cycle after a read request |
| cnv_start_o | output | 1 | One-cycle start pulse to the converter |
| cnv_sel_o | output | 6 | Physical input routed to the converter |
| cnv_done_i | input | 1 | Converter completion pulse, result valid |
| cnv_result_i | input | 12 | Conversion result |

## Verification
Two events can land on the same edge: the hardware capture of a result, which sets the channel's done flag, and a CPU read of that result word, which clears it. The bench provokes this by taking manual control of the converter model. It raises the completion pulse in exactly the cycle in which it issues the read of the converting channel's result word. The outcome is correct if that read returns the previous result, the control word still shows the done flag set, and a second read returns the new value and then clears the flag.

// File: rtl/adc_lch_pkg.sv
package adc_lch_pkg;
  localparam int SEL_W  = 6;
  localparam int WORD_W = 12;

  // control word bit positions (bits [5:0] hold the input select)
  localparam int B_PROT  = 6;
  localparam int B_MULTI = 7;
  localparam int B_GIE   = 8;
  localparam int B_PEND  = 9;
  localparam int B_DONE  = 10;
  localparam int B_GRP   = 11;

  typedef struct packed {
    logic             gie;
    logic             multi;
    logic             prot;
    logic [SEL_W-1:0] sel;
  } ch_cfg_t;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/adc_lch_regs.sv
module adc_lch_regs
  import adc_lch_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int CH_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic [NUM_CH-1:0] grp_evt_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [CH_W:0]     bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              start_fire_i,
  input  logic [NUM_CH-1:0] start_oh_i,
  input  logic              res_wr_i,
  input  logic [CH_W-1:0]   res_ch_i,
  input  logic [WORD_W-1:0] res_data_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] prot_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] grp_blk_o,
  output logic [SEL_W-1:0]  sel_tab_o [NUM_CH]
);
  logic [CH_W-1:0]   addr_ch;
  logic              addr_res;
  logic [WORD_W-1:0] ctl_word [NUM_CH];
  logic [WORD_W-1:0] res_word [NUM_CH];
  logic [WORD_W-1:0] rdata_q;
  logic              unused_wbits;

  assign addr_ch      = bus_addr_i[CH_W-1:0];
  assign addr_res     = bus_addr_i[CH_W];
  assign unused_wbits = bus_wdata_i[B_DONE];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_cfg_t           cfg_q;
    logic              pend_q, done_q, grp_q, mst_q;
    logic [WORD_W-1:0] res_q;
    logic              hit, ctl_wr, res_rd, st_hit, wr_hit;

    assign hit    = bus_req_i && (addr_ch == CH_W'(c));
    assign ctl_wr = hit && bus_we_i && !addr_res;
    assign res_rd = hit && !bus_we_i && addr_res;
    assign st_hit = start_fire_i && start_oh_i[c];
    assign wr_hit = res_wr_i && (res_ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q  <= '0;
        pend_q <= 1'b0;
        done_q <= 1'b0;
        grp_q  <= 1'b0;
        mst_q  <= 1'b0;
        res_q  <= '0;
      end else begin
        if (ctl_wr) cfg_q <= ch_cfg_t'(bus_wdata_i[B_GIE:0]);
        // a new trigger in the start cycle re-arms the channel
        if (trig_i[c] || (ctl_wr && bus_wdata_i[B_PEND])) pend_q <= 1'b1;
        else if (st_hit)                                 pend_q <= 1'b0;
        // hardware set beats the read clear
        if (wr_hit)      done_q <= 1'b1;
        else if (res_rd) done_q <= 1'b0;
        if (grp_evt_i[c])                    grp_q <= 1'b1;
        else if (ctl_wr && bus_wdata_i[B_GRP]) grp_q <= 1'b0;
        if (st_hit && cfg_q.multi)             mst_q <= 1'b1;
        else if (ctl_wr && bus_wdata_i[B_GRP]) mst_q <= 1'b0;
        if (wr_hit) res_q <= res_data_i;
      end
    end

    assign ctl_word[c]  = {grp_q, done_q, pend_q, cfg_q};
    assign res_word[c]  = res_q;
    assign pend_o[c]    = pend_q;
    assign prot_o[c]    = cfg_q.prot;
    assign done_o[c]    = done_q;
    assign grp_blk_o[c] = cfg_q.prot && cfg_q.multi && cfg_q.gie && grp_q && mst_q;
    assign sel_tab_o[c] = cfg_q.sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdata_q <= '0;
    else if (bus_req_i && !bus_we_i) rdata_q <= addr_res ? res_word[addr_ch] : ctl_word[addr_ch];
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/adc_lch_arb.sv
module adc_lch_arb #(
  parameter int NUM_CH = 64,
  parameter int CH_W   = 6
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [CH_W-1:0]   idx_o,
  output logic              any_o
);
  logic seen;

  // fixed priority: lowest index first
  always_comb begin
    seen = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      gnt_o[c] = req_i[c] && !seen;
      seen     = seen || req_i[c];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (gnt_o[c]) idx_o = idx_o | CH_W'(c);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/adc_lch_seq.sv
module adc_lch_seq
  import adc_lch_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_any_i,
  input  logic [CH_W-1:0]   gnt_idx_i,
  input  logic [SEL_W-1:0]  gnt_sel_i,
  input  logic              cnv_done_i,
  input  logic [WORD_W-1:0] cnv_result_i,
  output logic              start_fire_o,
  output logic              cnv_start_o,
  output logic [SEL_W-1:0]  cnv_sel_o,
  output logic              res_wr_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic [WORD_W-1:0] res_data_o
);
  seq_state_t       st_q;
  logic [CH_W-1:0]  ch_q;
  logic [SEL_W-1:0] sel_q;
  logic             start_q;

  assign start_fire_o = (st_q == SQ_IDLE) && gnt_any_i;
  assign res_wr_o     = (st_q == SQ_BUSY) && cnv_done_i;
  assign res_ch_o     = ch_q;
  assign res_data_o   = cnv_result_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      ch_q    <= '0;
      sel_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_fire_o;
      if (start_fire_o) begin
        st_q  <= SQ_BUSY;
        ch_q  <= gnt_idx_i;
        sel_q <= gnt_sel_i;
      end else if (res_wr_o) begin
        st_q <= SQ_IDLE;
      end
    end
  end

  assign cnv_start_o = start_q;
  assign cnv_sel_o   = sel_q;
endmodule

// File: rtl/adc_lch_sched.sv
module adc_lch_sched
  import adc_lch_pkg::*;
#(
  parameter  int NUM_CH = 64,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic [NUM_CH-1:0] grp_evt_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              cnv_start_o,
  output logic [SEL_W-1:0]  cnv_sel_o,
  input  logic              cnv_done_i,
  input  logic [WORD_W-1:0] cnv_result_i
);
  logic [NUM_CH-1:0] pend_v, prot_v, done_v, grp_blk_v, elig, gnt_oh;
  logic [CH_W-1:0]   gnt_idx, res_ch;
  logic              gnt_any, gnt_fire, res_wr;
  logic [SEL_W-1:0]  sel_tab [NUM_CH];
  logic [SEL_W-1:0]  gnt_sel;
  logic [WORD_W-1:0] res_data;

  adc_lch_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .grp_evt_i   (grp_evt_i),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .start_fire_i(gnt_fire),
    .start_oh_i  (gnt_oh),
    .res_wr_i    (res_wr),
    .res_ch_i    (res_ch),
    .res_data_i  (res_data),
    .pend_o      (pend_v),
    .prot_o      (prot_v),
    .done_o      (done_v),
    .grp_blk_o   (grp_blk_v),
    .sel_tab_o   (sel_tab)
  );

  // guard rule: unread result or interrupted multi-conversion holds a channel
  assign elig = pend_v & ~(prot_v & done_v) & ~grp_blk_v;

  adc_lch_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) arb_i (
    .req_i(elig),
    .gnt_o(gnt_oh),
    .idx_o(gnt_idx),
    .any_o(gnt_any)
  );

  assign gnt_sel = sel_tab[gnt_idx];

  adc_lch_seq #(.CH_W(CH_W)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_any_i   (gnt_any),
    .gnt_idx_i   (gnt_idx),
    .gnt_sel_i   (gnt_sel),
    .cnv_done_i  (cnv_done_i),
    .cnv_result_i(cnv_result_i),
    .start_fire_o(gnt_fire),
    .cnv_start_o (cnv_start_o),
    .cnv_sel_o   (cnv_sel_o),
    .res_wr_o    (res_wr),
    .res_ch_o    (res_ch),
    .res_data_o  (res_data)
  );
endmodule

// File: rtl/adc_lch_sched_chk.sv
module adc_lch_sched_chk
  import adc_lch_pkg::*;
#(
  parameter  int NUM_CH = 64,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnv_start_i,
  input logic [SEL_W-1:0]  cnv_sel_i,
  input logic              cnv_done_i,
  input logic              gnt_fire_i,
  input logic [NUM_CH-1:0] gnt_oh_i,
  input logic [NUM_CH-1:0] prot_v_i,
  input logic [NUM_CH-1:0] done_v_i,
  input logic              res_wr_i,
  input logic [CH_W-1:0]   res_ch_i
);
  logic inflight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          inflight <= 1'b0;
    else if (cnv_start_i) inflight <= 1'b1;
    else if (cnv_done_i)  inflight <= 1'b0;
  end

  assert_start_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_start_i |=> !cnv_start_i);

  assert_single_inflight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight |-> !cnv_start_i);

  assert_sel_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight && !cnv_done_i) |=> $stable(cnv_sel_i));

  assert_grant_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_oh_i));

  assert_guard_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_fire_i |-> ((gnt_oh_i & prot_v_i & done_v_i) == '0));

  assert_done_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr_i |=> done_v_i[$past(res_ch_i)]);
endmodule

bind adc_lch_sched adc_lch_sched_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnv_start_i(cnv_start_o),
  .cnv_sel_i  (cnv_sel_o),
  .cnv_done_i (cnv_done_i),
  .gnt_fire_i (gnt_fire),
  .gnt_oh_i   (gnt_oh),
  .prot_v_i   (prot_v),
  .done_v_i   (done_v),
  .res_wr_i   (res_wr),
  .res_ch_i   (res_ch)
);

// File: tb/adc_lch_sched_tb_top.sv
module adc_lch_sched_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  trig = '0, grp_evt = '0;
  logic            req = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [11:0]     wdata = '0;
  logic [11:0]     rdata;
  logic            cnv_start;
  logic [5:0]      cnv_sel;
  logic            cnv_done;
  logic [11:0]     cnv_res;

  bit              auto_cnv = 1'b1;
  logic            auto_done = 1'b0, man_done = 1'b0;
  logic [11:0]     auto_res = '0, man_res = '0;
  int              n_start = 0, n_done = 0, lat_cnt = 0, sel_bad = 0;
  bit              busy_m = 1'b0;
  logic [5:0]      cur_sel = '0;
  logic [5:0]      sel_log [64];
  logic [11:0]     res_log [64];
  int              checks = 0, failures = 0;

  always #4 clk = ~clk;

  assign cnv_done = auto_done | man_done;
  assign cnv_res  = man_done ? man_res : auto_res;

  adc_lch_sched #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .grp_evt_i(grp_evt),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cnv_start_o(cnv_start), .cnv_sel_o(cnv_sel),
    .cnv_done_i(cnv_done), .cnv_result_i(cnv_res)
  );

  function automatic logic [11:0] model_res(logic [5:0] s, int n);
    return 12'((int'(s) * 37 + n * 5 + 1) % 4096);
  endfunction

  function automatic logic [5:0] sel_of(int k);
    return (k >= 4 && k <= 6) ? 6'd8 : 6'((k * 11 + 3) % 64);
  endfunction

  // converter model: done three cycles after the start pulse
  always @(negedge clk) begin
    auto_done = 1'b0;
    if (auto_cnv) begin
      if (busy_m) begin
        if (cnv_sel !== cur_sel) sel_bad++;
        if (lat_cnt == 0) begin
          auto_res = model_res(cur_sel, n_done);
          auto_done = 1'b1;
          res_log[n_done] = auto_res;
          n_done++;
          busy_m = 1'b0;
        end else lat_cnt--;
      end
      if (cnv_start) begin
        busy_m = 1'b1;
        cur_sel = cnv_sel;
        sel_log[n_start] = cnv_sel;
        n_start++;
        lat_cnt = 2;
      end
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [11:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [11:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic wait_done(int target);
    int w = 0;
    while (n_done < target && w < 60) begin
      @(negedge clk);
      w++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over every address
    for (int a = 0; a < 2 * NCH; a++) begin
      bus_rd(a, d);
      chk("R1", "reset word", d, 0);
    end
    chk("R1", "start low", cnv_start, 0);
    chk("R1", "sel zero", cnv_sel, 0);

    // R2/R7/R3: map channels, channels 4..6 share input 8, trigger all at once
    for (int k = 0; k < NCH; k++) bus_wr(k, {6'd0, sel_of(k)});
    @(negedge clk); trig = '1;
    @(negedge clk); trig = '0;
    wait_done(NCH);
    chk("R7", "conversions", n_done, NCH);
    for (int k = 0; k < NCH; k++) begin
      chk("R7", "start order sel (R2)", sel_log[k], sel_of(k));
      bus_rd(k, d);
      chk("R7", "done set, pend clear", d, 12'h400 | 12'(sel_of(k)));
      bus_rd(NCH + k, d);
      chk("R3", "result word", d, model_res(sel_of(k), k));
      bus_rd(k, d);
      chk("R10", "read clears done", d, 12'(sel_of(k)));
    end

    // R4/R11: unguarded channel overwritten while done still set
    base = n_done;
    bus_wr(1, 12'h200 | 12'(sel_of(1)));
    wait_done(base + 1);
    bus_wr(1, 12'h200 | 12'(sel_of(1)));
    wait_done(base + 2);
    chk("R4", "second conversion ran", n_done, base + 2);
    bus_rd(NCH + 1, d);
    chk("R4", "overwritten result", d, model_res(sel_of(1), base + 1));

    // R5: guarded channel with unread result is skipped
    base = n_done;
    bus_wr(2, 12'h240 | 12'(sel_of(2)));
    wait_done(base + 1);
    @(negedge clk); trig = 8'b0000_1100;
    @(negedge clk); trig = '0;
    wait_done(base + 2);
    repeat (15) @(negedge clk);
    chk("R5", "only one conversion", n_done, base + 2);
    chk("R5", "channel 3 went", sel_log[base + 1], sel_of(3));
    bus_rd(2, d);
    chk("R5", "held pending+done", d, 12'h640 | 12'(sel_of(2)));
    bus_rd(NCH + 2, d);
    chk("R5", "kept result", d, model_res(sel_of(2), base));
    wait_done(base + 3);
    chk("R5", "released after read", n_done, base + 3);
    chk("R5", "released sel", sel_log[base + 2], sel_of(2));
    bus_rd(NCH + 2, d);

    // R6: multi-conversion channel blocked by group interruption
    base = n_done;
    bus_wr(5, 12'h3C8);
    wait_done(base + 1);
    bus_rd(NCH + 5, d);
    @(negedge clk); grp_evt = 8'h20;
    @(negedge clk); grp_evt = '0;
    bus_rd(5, d);
    chk("R11", "group flag set", d, 12'h9C8);
    @(negedge clk); trig = 8'h20;
    @(negedge clk); trig = '0;
    repeat (15) @(negedge clk);
    chk("R6", "blocked by group flag", n_done, base + 1);
    bus_rd(5, d);
    chk("R6", "pending held", d, 12'hBC8);
    bus_wr(5, 12'h9C8);
    wait_done(base + 2);
    chk("R6", "released by flag clear", n_done, base + 2);
    bus_rd(NCH + 5, d);
    @(negedge clk); grp_evt = 8'h20;
    @(negedge clk); grp_evt = '0;
    bus_wr(5, 12'h2C8);
    wait_done(base + 3);
    chk("R6", "enable off does not block", n_done, base + 3);
    bus_rd(NCH + 5, d);

    // R9/R10: manual converter, capture and read in the same cycle
    auto_cnv = 1'b0;
    bus_wr(7, 12'h200 | 12'(sel_of(7)));
    for (int w = 0; w < 20 && !cnv_start; w++) @(negedge clk);
    chk("R8", "start pulse seen", cnv_start, 1);
    chk("R2", "started sel", cnv_sel, sel_of(7));
    bus_wr(7, 12'h03F);
    repeat (3) @(negedge clk);
    chk("R9", "sel held after rewrite", cnv_sel, sel_of(7));
    chk("R8", "no restart while busy", cnv_start, 0);
    @(negedge clk);
    man_done = 1'b1; man_res = 12'h5A5;
    req = 1'b1; we = 1'b0; addr = AW'(NCH + 7);
    @(negedge clk);
    man_done = 1'b0; req = 1'b0;
    chk("R10", "collision read old value", rdata, model_res(sel_of(7), 7));
    bus_rd(7, d);
    chk("R10", "done survives read", d, 12'h43F);
    bus_rd(NCH + 7, d);
    chk("R3", "new result", d, 12'h5A5);
    bus_rd(7, d);
    chk("R10", "second read clears", d, 12'h03F);
    chk("R9", "sel unstable cycles", sel_bad, 0);

    summary();
    $finish;
  end
endmodule